// File: doc/BRIEF.md
# Shared Processor-Hot Pin Thermal Controller

This block runs at package level in a multi-core device (two cores by default) and owns the one processor-hot pin the package exposes. The pin is active-low and open-drain. The block pulls it low whenever any core reports a thermal trip. It also samples the pin, so an outside agent that pulls the pin low can make the cores throttle.

The block turns the pin state and the per-core trips into per-core throttle requests. Two policies are available. In clock-modulation mode, only the cores that tripped are modulated. In performance-state mode, every core is asked to drop to its lowest performance state. Edge interrupts can be enabled separately for assertion and for deassertion of the pin. Each edge sets its own sticky status bit, and software clears that bit by writing one to it.

The internal reset is asserted asynchronously and released synchronously. Outputs respond two cycles after `rst_n` rises.

Top module: `hotpin_arbiter`

## Requirements
- R1: `pin_drive_o` (1 = pull the pin low) goes high in the cycle after any bit of `core_trip_i` is sampled high at a clock edge. It is low in the cycle after an edge where all trips are sampled low.
- R2: `pin_in_i` is active-low (0 = pin asserted). It passes through a two-flop synchronizer, so a level change seen at edge a takes effect on the throttle outputs after edge a+1.
- R3: When only clock modulation is enabled (`en_clkmod_i`=1, `en_pstate_i`=0) and a core trip is registered, `clkmod_en_o[i]` equals that core's registered trip bit. `pstate_low_o` is all zero.
- R4: When only clock modulation is enabled and the pin is asserted by an external agent alone, with no core trip during the synchronizer window, every bit of `clkmod_en_o` is 1.
- R5: When `en_pstate_i`=1, a registered trip or a synchronized pin assertion sets every bit of `pstate_low_o`, and `clkmod_en_o` stays all zero. This holds whatever the value of `en_clkmod_i`.
- R6: With both mode enables at 0, `clkmod_en_o` and `pstate_low_o` are all zero. `pin_drive_o` still follows the trips.
- R7: A synchronized pin assertion with `irq_rise_en_i`=1 sets `sts_assert_o` and pulses `irq_o` for one cycle. Both happen after edge a+2, where a is the edge that first sampled the pin low.
- R8: A synchronized pin deassertion with `irq_fall_en_i`=1 sets `sts_deassert_o` and pulses `irq_o` with the same latency as R7.
- R9: An edge whose enable is 0 sets no status bit and raises no `irq_o`.
- R10: `sts_clr_i[0]` clears `sts_assert_o` and `sts_clr_i[1]` clears `sts_deassert_o`, one cycle after the clear is sampled. A new edge in the same cycle wins over the clear.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_trip_i | input | NUM_CORES | Per-core thermal trip |
| en_clkmod_i | input | 1 | Enable clock-modulation policy |
| en_pstate_i | input | 1 | Enable lowest-performance-state policy |
| pin_in_i | input | 1 | Raw pin level, active-low |
| irq_rise_en_i | input | 1 | Interrupt enable for pin assertion |
| irq_fall_en_i | input | 1 | Interrupt enable for pin deassertion |
| sts_clr_i | input | 2 | Write-one-to-clear: bit0 assert status, bit1 deassert status |
| pin_drive_o | output | 1 | Open-drain pull-down enable |
| clkmod_en_o | output | NUM_CORES | Per-core clock-modulation enable |
| pstate_low_o | output | NUM_CORES | Per-core lowest-performance-state request |
| irq_o | output | 1 | One-cycle edge interrupt pulse |
| sts_assert_o | output | 1 | Sticky pin-assertion status |
| sts_deassert_o | output | 1 | Sticky pin-deassertion status |

## Verification
The bench sweeps every combination of mode enables, trip patterns and external pull. It checks the steady-state pin drive and the throttle vectors against an arithmetic model. A design that confused the hot core with its neighbour, or that let clock modulation win over the performance-state policy, fails this sweep.

The timing checks count edges through the synchronizer and the interrupt register. A design with one synchronizer stage too many or too few would move the pulse by a cycle. So would a level-sensitive interrupt. The tests also cover a clear that coincides with a new edge, and edges arriving while their enable is 0. A design that gave the clear priority, or that ignored the enables, would be caught here.

// File: rtl/hotpin_pkg.sv
package hotpin_pkg;

  typedef enum logic [1:0] {
    POL_NONE   = 2'd0,
    POL_CLKMOD = 2'd1,
    POL_PSTATE = 2'd2
  } hot_policy_e;

  // Performance-state policy wins when both enables are set.
  function automatic hot_policy_e pick_policy(input logic clkmod_en, input logic pstate_en);
    hot_policy_e p;
    if (pstate_en)      p = POL_PSTATE;
    else if (clkmod_en) p = POL_CLKMOD;
    else                p = POL_NONE;
    return p;
  endfunction

endpackage

// File: rtl/hotpin_rst_sync.sv
module hotpin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/hotpin_sync.sv
module hotpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d_i;
    for (int k = 1; k < STAGES; k++) chain_d[k] = chain_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hotpin_policy.sv
module hotpin_policy
  import hotpin_pkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic [NUM_CORES-1:0]   trip_q_i,
  input  logic [SYNC_STAGES-1:0] own_hist_i,
  input  logic                   pin_act_i,
  input  logic                   en_clkmod_i,
  input  logic                   en_pstate_i,
  output logic [NUM_CORES-1:0]   clkmod_en_o,
  output logic [NUM_CORES-1:0]   pstate_low_o
);
  hot_policy_e policy;
  logic        any_trip;
  logic        own_recent;
  logic        ext_only;
  logic        throttle_all;

  always_comb begin
    policy       = pick_policy(en_clkmod_i, en_pstate_i);
    any_trip     = |trip_q_i;
    // Our own pull shows on the synced pin for SYNC_STAGES cycles after release.
    own_recent   = any_trip | (|own_hist_i);
    ext_only     = pin_act_i & ~own_recent;
    throttle_all = any_trip | pin_act_i;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_comb begin
      clkmod_en_o[c]  = 1'b0;
      pstate_low_o[c] = 1'b0;
      unique case (policy)
        POL_PSTATE: pstate_low_o[c] = throttle_all;
        POL_CLKMOD: clkmod_en_o[c]  = trip_q_i[c] | ext_only;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hotpin_edge_irq.sv
module hotpin_edge_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_act_i,
  input  logic       rise_en_i,
  input  logic       fall_en_i,
  input  logic [1:0] clr_i,
  output logic       irq_o,
  output logic       sts_rise_o,
  output logic       sts_fall_o
);
  logic act_q, act_d;
  logic irq_q, irq_d;
  logic sr_q, sr_d;
  logic sf_q, sf_d;
  logic rise_hit, fall_hit;

  always_comb begin
    rise_hit = pin_act_i & ~act_q & rise_en_i;
    fall_hit = ~pin_act_i & act_q & fall_en_i;
    act_d    = pin_act_i;
    irq_d    = rise_hit | fall_hit;
    // A fresh edge wins over a clear arriving in the same cycle.
    sr_d     = (sr_q & ~clr_i[0]) | rise_hit;
    sf_d     = (sf_q & ~clr_i[1]) | fall_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      irq_q <= 1'b0;
      sr_q  <= 1'b0;
      sf_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      irq_q <= irq_d;
      sr_q  <= sr_d;
      sf_q  <= sf_d;
    end
  end

  assign irq_o      = irq_q;
  assign sts_rise_o = sr_q;
  assign sts_fall_o = sf_q;
endmodule

// File: rtl/hotpin_arbiter.sv
module hotpin_arbiter #(
  parameter int NUM_CORES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] core_trip_i,
  input  logic                 en_clkmod_i,
  input  logic                 en_pstate_i,
  input  logic                 pin_in_i,
  input  logic                 irq_rise_en_i,
  input  logic                 irq_fall_en_i,
  input  logic [1:0]           sts_clr_i,
  output logic                 pin_drive_o,
  output logic [NUM_CORES-1:0] clkmod_en_o,
  output logic [NUM_CORES-1:0] pstate_low_o,
  output logic                 irq_o,
  output logic                 sts_assert_o,
  output logic                 sts_deassert_o
);
  logic                   rst_sync_n;
  logic [NUM_CORES-1:0]   trip_q, trip_d;
  logic [SYNC_STAGES-1:0] own_hist_q, own_hist_d;
  logic                   pin_act;

  hotpin_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hotpin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (~pin_in_i),
    .q_o   (pin_act)
  );

  always_comb begin
    trip_d        = core_trip_i;
    own_hist_d[0] = |trip_q;
    for (int k = 1; k < SYNC_STAGES; k++) own_hist_d[k] = own_hist_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      trip_q     <= '0;
      own_hist_q <= '0;
    end else begin
      trip_q     <= trip_d;
      own_hist_q <= own_hist_d;
    end
  end

  assign pin_drive_o = |trip_q;

  hotpin_policy #(.NUM_CORES(NUM_CORES), .SYNC_STAGES(SYNC_STAGES)) u_policy (
    .trip_q_i     (trip_q),
    .own_hist_i   (own_hist_q),
    .pin_act_i    (pin_act),
    .en_clkmod_i  (en_clkmod_i),
    .en_pstate_i  (en_pstate_i),
    .clkmod_en_o  (clkmod_en_o),
    .pstate_low_o (pstate_low_o)
  );

  hotpin_edge_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pin_act_i  (pin_act),
    .rise_en_i  (irq_rise_en_i),
    .fall_en_i  (irq_fall_en_i),
    .clr_i      (sts_clr_i),
    .irq_o      (irq_o),
    .sts_rise_o (sts_assert_o),
    .sts_fall_o (sts_deassert_o)
  );
endmodule

// File: rtl/hotpin_arbiter_chk.sv
module hotpin_arbiter_chk #(
  parameter int NUM_CORES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] core_trip_i,
  input logic                 en_clkmod_i,
  input logic                 en_pstate_i,
  input logic                 irq_rise_en_i,
  input logic [1:0]           sts_clr_i,
  input logic                 pin_drive_o,
  input logic [NUM_CORES-1:0] clkmod_en_o,
  input logic [NUM_CORES-1:0] pstate_low_o,
  input logic                 sts_assert_o
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_drive_on_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_trip_i) |=> pin_drive_o);

  assert_drive_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(|core_trip_i) |=> !pin_drive_o);

  assert_hot_core_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && en_clkmod_i && !en_pstate_i && (|$past(core_trip_i)))
      |-> (clkmod_en_o == $past(core_trip_i)) && (pstate_low_o == '0));

  assert_pstate_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pstate_i && pin_drive_o) |-> (&pstate_low_o) && (clkmod_en_o == '0));

  assert_modes_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_clkmod_i && !en_pstate_i) |-> (clkmod_en_o == '0) && (pstate_low_o == '0));

  assert_assert_sts_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(sts_assert_o)) |-> $past(irq_rise_en_i));

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_assert_o && !sts_clr_i[0]) |=> sts_assert_o);
endmodule

bind hotpin_arbiter hotpin_arbiter_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .core_trip_i   (core_trip_i),
  .en_clkmod_i   (en_clkmod_i),
  .en_pstate_i   (en_pstate_i),
  .irq_rise_en_i (irq_rise_en_i),
  .sts_clr_i     (sts_clr_i),
  .pin_drive_o   (pin_drive_o),
  .clkmod_en_o   (clkmod_en_o),
  .pstate_low_o  (pstate_low_o),
  .sts_assert_o  (sts_assert_o)
);

// File: tb/sim_hotpin_arbiter.sv
`timescale 1ns/1ps
module sim_hotpin_arbiter;
  localparam int NC = 2;

  logic          clk;
  logic          rst_n;
  logic [NC-1:0] core_trip;
  logic          en_cm, en_ps, ext_pull;
  logic          ren, fen;
  logic [1:0]    clr;
  logic          pin;
  logic          drive;
  logic [NC-1:0] cm, pl;
  logic          irq, sa, sd;
  int            n_chk, n_fail, cyc;

  assign pin = ~(drive | ext_pull);

  hotpin_arbiter #(.NUM_CORES(NC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .core_trip_i(core_trip),
    .en_clkmod_i(en_cm), .en_pstate_i(en_ps), .pin_in_i(pin),
    .irq_rise_en_i(ren), .irq_fall_en_i(fen), .sts_clr_i(clr),
    .pin_drive_o(drive), .clkmod_en_o(cm), .pstate_low_o(pl),
    .irq_o(irq), .sts_assert_o(sa), .sts_deassert_o(sd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [NC-1:0] e_cm, e_pl;
    logic          e_drv, seen;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; core_trip = '0; en_cm = 0; en_ps = 0; ext_pull = 0;
    ren = 0; fen = 0; clr = 2'b00;
    nwait(3);
    rst_n = 1'b1;
    nwait(4);
    // R11 reset state
    chk("R11 outputs", {drive, cm, pl, irq, sa, sd}, '0);

    // R1 latency: trip set at a negedge, visible right after the next edge
    core_trip = 2'b10;
    #1;
    chk("R1 before edge", drive, 1'b0);
    nwait(1);
    chk("R1 after edge", drive, 1'b1);
    core_trip = '0;
    nwait(1);
    chk("R1 release", drive, 1'b0);
    nwait(4);

    // Sweep modes x trips x external pull; steady-state model (R3 R4 R5 R6 R1)
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 4; t++) begin
        for (int x = 0; x < 2; x++) begin
          en_cm = m[0]; en_ps = m[1]; core_trip = t[NC-1:0]; ext_pull = x[0];
          nwait(6);
          e_drv = (t != 0);
          e_cm  = '0; e_pl = '0;
          if (m[1]) e_pl = (e_drv || x[0]) ? '1 : '0;
          else if (m[0]) e_cm = t[NC-1:0] | ((x[0] && !e_drv) ? '1 : '0);
          chk("R1 sweep drive", drive, e_drv);
          if (m == 0)      chk("R6 sweep", {cm, pl}, {e_cm, e_pl});
          else if (m[1])   chk("R5 sweep", {cm, pl}, {e_cm, e_pl});
          else if (t != 0) chk("R3 sweep", {cm, pl}, {e_cm, e_pl});
          else             chk("R4 sweep", {cm, pl}, {e_cm, e_pl});
        end
      end
    end
    core_trip = '0; ext_pull = 0; en_cm = 1; en_ps = 0;
    nwait(6);
    clr = 2'b11; nwait(1); clr = 2'b00;

    // R2 + R7: external pull, count edges through the synchronizer
    ren = 1; fen = 1;
    ext_pull = 1;                    // edge a samples it
    nwait(1);                        // after a
    chk("R2 not yet", cm, 2'b00);
    nwait(1);                        // after a+1
    chk("R2 sync done", cm, 2'b11);
    chk("R7 no early irq", {irq, sa}, 2'b00);
    nwait(1);                        // after a+2
    chk("R7 irq pulse", {irq, sa}, 2'b11);
    nwait(1);
    chk("R7 pulse one cycle", {irq, sa}, 2'b01);
    clr = 2'b01; nwait(1); clr = 2'b00;
    chk("R10 clear assert", sa, 1'b0);

    // R8 deassertion
    ext_pull = 0;
    nwait(2);
    chk("R8 no early irq", {irq, sd}, 2'b00);
    nwait(1);
    chk("R8 irq pulse", {irq, sd}, 2'b11);
    nwait(1);
    chk("R8 pulse one cycle", {irq, sd}, 2'b01);
    clr = 2'b10; nwait(1); clr = 2'b00;
    chk("R10 clear deassert", sd, 1'b0);

    // R9 disabled edges leave status and irq untouched
    ren = 0; fen = 0; seen = 0;
    ext_pull = 1;
    for (int k = 0; k < 6; k++) begin nwait(1); seen |= irq; end
    ext_pull = 0;
    for (int k = 0; k < 6; k++) begin nwait(1); seen |= irq; end
    chk("R9 no irq", seen, 1'b0);
    chk("R9 no status", {sa, sd}, 2'b00);

    // R10 set wins over simultaneous clear, then clear takes effect
    ren = 1;
    clr = 2'b01;
    ext_pull = 1;
    nwait(3);
    chk("R10 set wins", sa, 1'b1);
    nwait(1);
    chk("R10 clear after", sa, 1'b0);
    clr = 2'b00; ext_pull = 0; ren = 0;
    nwait(6);

    // R7 via internal trip: own drive also raises the assertion edge
    ren = 1;
    core_trip = 2'b01;               // edge k registers trip; pin low after k
    nwait(1);
    chk("R3 hot core only", cm, 2'b01);
    nwait(2);                        // a = k+1, pulse after k+3
    chk("R7 internal early", sa, 1'b0);
    nwait(1);
    chk("R7 internal pulse", {irq, sa}, 2'b11);
    core_trip = '0;
    nwait(3);
    chk("R4 own tail masked", cm, 2'b00);
    nwait(4);
    finish_run();
  end
endmodule